// File: doc/BRIEF.md
# Two-Level Masked Chip-Select Decoder

This block turns a 24-bit bus address into one of sixteen chip-select lines, organised as four groups of four. A select fires only when two comparisons both agree. The first is a coarse match of the address top byte against its group's compare/mask pair. The second is a match of the address against the select's own compare/mask pair. Groups 0 and 1 resolve regions down to 64 KiB, using address bits 23..16. Groups 2 and 3 resolve down to 4 KiB, using address bits 23..12. In every mask a 1 marks that bit as don't-care.

Each select carries its own attributes: a port width (8 or 16 bit), a read-only flag and a 3-bit wait-state count. When an address strobe is first seen high, the block registers the winning select together with its width and wait count. It flags a bus error, and drives no select, when the access is a write that lands in a read-only region. All registers sit behind a small indexed write/read port.

Top module: `csel_decoder`

## Requirements
- R1: Selects in groups 0 and 1 compare only address bits 23..16, and bits 15..12 never affect them. Selects in groups 2 and 3 compare address bits 23..12.
- R2: A select matches only when its group's match on address bits 23..16 is true AND its own masked compare is true. Select i belongs to group i/4.
- R3: In every compare, a mask bit of 1 makes that address bit don't-care, and a mask bit of 0 requires equality.
- R4: Select register i (index 0..15) has this layout: compare of address 23..12 in bits 31..20, bits 19..17 reading 0, width in bit 16 (0 = 8-bit, 1 = 16-bit), mask of address 23..12 in bits 15..4, read-only in bit 3, and wait count in bits 2..0. Each resets to 0x00010006. For groups 0 and 1, bits 23..20 and 7..4 read 0. Indices 20..31 read 0 and ignore writes.
- R5: Group register g sits at index 16+g. Bits 15..8 hold the compare of address 23..16 and bits 7..0 hold its mask. Upper bits read 0, and the register resets to 0.
- R6: When several selects match, only the lowest-numbered one asserts, so at most one select line is ever high.
- R7: An access that matches no select raises no_sel with every select low, no bus error, and width and wait both 0.
- R8: For a matching access, wide and wait_cnt report the winning select's width bit and wait count.
- R9: A write that hits a read-only select raises bus_err and drives no select. A read of the same region asserts the select normally.
- R10: Outputs are captured at the first clock with bus_strobe high, held unchanged while it stays high even if address or direction change, and cleared to 0 at the clock after it goes low. Everything is 0 in and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Bus address |
| bus_write | input | 1 | 1 = write access |
| bus_strobe | input | 1 | Address valid, active high |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| cs | output | 16 | Chip-select lines, one-hot or zero |
| no_sel | output | 1 | Access matched no select |
| wide | output | 1 | Winning region is 16-bit |
| wait_cnt | output | 3 | Winning region wait states |
| bus_err | output | 1 | Write to a read-only region |

## Verification
The bench sweeps all 4096 values of address bits 23..12, for both reads and writes, over a configuration built around the hard cases. It includes overlapping selects where a priority slip would assert the wrong or several lines, and a group-1 select whose own compare matches while its group does not, which catches a decoder that skips the group level. It also includes coarse-group selects programmed with junk in bits 15..12, where a design that honoured them would miss, and read-only regions where a write that still strobed the select would show up directly. A hold test changes address and direction mid-strobe to expose outputs that track the bus instead of latching. Register readback checks the reset value, the zeroed unused fields and the unmapped indices.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W   = 24;
  localparam int FINE_W   = 12;
  localparam int COARSE_W = 8;
  localparam int REG_W    = 32;
  localparam int WAIT_W   = 3;

  // field order is significant: it is the register bit layout, msb first
  typedef struct packed {
    logic [FINE_W-1:0] cmp;
    logic [2:0]        spare;
    logic              wide;
    logic [FINE_W-1:0] mask;
    logic              ro;
    logic [WAIT_W-1:0] wt;
  } sel_reg_t;

  typedef struct packed {
    logic [COARSE_W-1:0] cmp;
    logic [COARSE_W-1:0] mask;
  } grp_reg_t;

  localparam logic [REG_W-1:0] SEL_RST     = 32'h0001_0006;
  localparam logic [REG_W-1:0] KEEP_FINE   = 32'hFFF1_FFFF;
  localparam logic [REG_W-1:0] KEEP_COARSE = 32'hFF01_FF0F;
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int N_GROUPS      = 4,
  parameter int SEL_PER_GRP   = 4,
  parameter int COARSE_GROUPS = 2,
  localparam int N_SEL        = N_GROUPS * SEL_PER_GRP,
  localparam int IDX_W        = $clog2(N_SEL + N_GROUPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output sel_reg_t [N_SEL-1:0]    sel_q,
  output grp_reg_t [N_GROUPS-1:0] grp_q
);
  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    localparam logic [REG_W-1:0] KEEP =
      ((i / SEL_PER_GRP) < COARSE_GROUPS) ? KEEP_COARSE : KEEP_FINE;
    sel_reg_t r;
    always_ff @(posedge clk) begin
      if (rst)                                r <= sel_reg_t'(SEL_RST);
      else if (we && idx == IDX_W'(i))        r <= sel_reg_t'(wdata & KEEP);
    end
    assign sel_q[i] = r;
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    grp_reg_t r;
    always_ff @(posedge clk) begin
      if (rst)                                r <= '0;
      else if (we && idx == IDX_W'(N_SEL + g)) r <= grp_reg_t'(wdata[2*COARSE_W-1:0]);
    end
    assign grp_q[g] = r;
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_SEL; i++)
      if (idx == IDX_W'(i)) rd_mux = sel_q[i];
    for (int g = 0; g < N_GROUPS; g++)
      if (idx == IDX_W'(N_SEL + g)) rd_mux = {{(REG_W-2*COARSE_W){1'b0}}, grp_q[g]};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int N_GROUPS      = 4,
  parameter int SEL_PER_GRP   = 4,
  parameter int COARSE_GROUPS = 2,
  localparam int N_SEL        = N_GROUPS * SEL_PER_GRP
) (
  input  logic [ADDR_W-1:0]       addr,
  input  sel_reg_t [N_SEL-1:0]    sel_q,
  input  grp_reg_t [N_GROUPS-1:0] grp_q,
  output logic [N_SEL-1:0]        hit
);
  localparam logic [FINE_W-1:0] LOW_DC = {{COARSE_W{1'b0}}, {(FINE_W-COARSE_W){1'b1}}};

  logic [COARSE_W-1:0] a_hi;
  logic [FINE_W-1:0]   a_fine;
  logic [N_GROUPS-1:0] grp_hit;

  assign a_hi   = addr[ADDR_W-1 -: COARSE_W];
  assign a_fine = addr[ADDR_W-1 -: FINE_W];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = ((a_hi ^ grp_q[g].cmp) & ~grp_q[g].mask) == '0;
  end

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    localparam int G = i / SEL_PER_GRP;
    logic [FINE_W-1:0] dc;
    if (G < COARSE_GROUPS) begin : g_coarse
      assign dc = sel_q[i].mask | LOW_DC;
    end else begin : g_fine
      assign dc = sel_q[i].mask;
    end
    assign hit[i] = grp_hit[G] && (((a_fine ^ sel_q[i].cmp) & ~dc) == '0);
  end
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // isolate the lowest set bit
  assign grant = req & (~req + N'(1));
  assign any   = |req;
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int N_GROUPS      = 4,
  parameter int SEL_PER_GRP   = 4,
  parameter int COARSE_GROUPS = 2,
  localparam int N_SEL        = N_GROUPS * SEL_PER_GRP,
  localparam int IDX_W        = $clog2(N_SEL + N_GROUPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_strobe,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [N_SEL-1:0]  cs,
  output logic              no_sel,
  output logic              wide,
  output logic [WAIT_W-1:0] wait_cnt,
  output logic              bus_err
);
  sel_reg_t [N_SEL-1:0]    sel_q;
  grp_reg_t [N_GROUPS-1:0] grp_q;
  logic [N_SEL-1:0]        hit, grant;
  logic                    any_hit;

  csel_regfile #(.N_GROUPS(N_GROUPS), .SEL_PER_GRP(SEL_PER_GRP),
                 .COARSE_GROUPS(COARSE_GROUPS)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel_q(sel_q), .grp_q(grp_q)
  );

  csel_match #(.N_GROUPS(N_GROUPS), .SEL_PER_GRP(SEL_PER_GRP),
               .COARSE_GROUPS(COARSE_GROUPS)) u_match (
    .addr(bus_addr), .sel_q(sel_q), .grp_q(grp_q), .hit(hit)
  );

  csel_prio #(.N(N_SEL)) u_prio (.req(hit), .grant(grant), .any(any_hit));

  logic              win_ro, win_wide;
  logic [WAIT_W-1:0] win_wt;
  always_comb begin
    win_ro   = 1'b0;
    win_wide = 1'b0;
    win_wt   = '0;
    for (int i = 0; i < N_SEL; i++) begin
      win_ro   = win_ro   | (grant[i] & sel_q[i].ro);
      win_wide = win_wide | (grant[i] & sel_q[i].wide);
      win_wt   = win_wt   | ({WAIT_W{grant[i]}} & sel_q[i].wt);
    end
  end

  logic strobe_q;
  logic wr_fault;
  assign wr_fault = any_hit && win_ro && bus_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;   // a strobe already high at reset release is not a new access
      cs       <= '0;
      no_sel   <= 1'b0;
      wide     <= 1'b0;
      wait_cnt <= '0;
      bus_err  <= 1'b0;
    end else begin
      strobe_q <= bus_strobe;
      if (!bus_strobe) begin
        cs       <= '0;
        no_sel   <= 1'b0;
        wide     <= 1'b0;
        wait_cnt <= '0;
        bus_err  <= 1'b0;
      end else if (!strobe_q) begin
        cs       <= wr_fault ? '0 : grant;
        no_sel   <= !any_hit;
        wide     <= win_wide;
        wait_cnt <= win_wt;
        bus_err  <= wr_fault;
      end
    end
  end
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
  parameter int N_SEL  = 16,
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_strobe,
  input logic              bus_write,
  input logic [N_SEL-1:0]  cs,
  input logic              no_sel,
  input logic              wide,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic              bus_err
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));

  assert_err_blocks_cs_R9: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (cs == '0));

  assert_err_from_write_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> $past(bus_write));

  assert_nosel_clean_R7: assert property (@(posedge clk) disable iff (rst)
    no_sel |-> (cs == '0 && !bus_err && !wide && wait_cnt == '0));

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_strobe) |-> (cs == '0 && !no_sel && !bus_err));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(bus_strobe) && $past(bus_strobe, 2)) |->
      ($stable(cs) && $stable(no_sel) && $stable(bus_err) && $stable(wide) && $stable(wait_cnt)));

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(bus_strobe) && !$past(bus_strobe, 2)) |->
      ({1'b0, |cs} + {1'b0, no_sel} + {1'b0, bus_err} == 2'd1));
endmodule

bind csel_decoder csel_decoder_chk #(.N_SEL(N_SEL), .WAIT_W(csel_pkg::WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_write(bus_write),
  .cs(cs), .no_sel(no_sel), .wide(wide), .wait_cnt(wait_cnt), .bus_err(bus_err)
);

// File: tb/sim_csel_decoder.sv
module sim_csel_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] bus_addr;
  logic        bus_write, bus_strobe;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] cs;
  logic        no_sel, wide, bus_err;
  logic [2:0]  wait_cnt;

  always #4 clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_strobe(bus_strobe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs(cs), .no_sel(no_sel),
    .wide(wide), .wait_cnt(wait_cnt), .bus_err(bus_err)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] sm [16];
  logic [15:0] gm [4];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [11:0] c, input logic [11:0] m,
                                     input logic w, input logic r, input logic [2:0] t);
    return {c, 3'b111, w, m, r, t};
  endfunction

  task automatic reg_wr(input int idx, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    if (idx < 16)      sm[idx] = v & ((idx < 8) ? 32'hFF01FF0F : 32'hFFF1FFFF);
    else if (idx < 20) gm[idx-16] = v[15:0];
  endtask

  task automatic reg_chk(input int idx, input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = 5'(idx);
    @(negedge clk);
    e = (idx < 16) ? sm[idx] : (idx < 20) ? {16'h0, gm[idx-16]} : 32'h0;
    check(tag, reg_rdata, e);
  endtask

  // packed: {cs, no_sel, wide, wait_cnt, bus_err}
  function automatic logic [21:0] model(input logic [23:0] a, input logic wr);
    bit found = 0;
    int w = 0;
    for (int i = 0; i < 16; i++) begin
      int g = i / 4;
      logic gh, sh;
      logic [11:0] dc;
      gh = ((a[23:16] ^ gm[g][15:8]) & ~gm[g][7:0]) == 8'h0;
      dc = sm[i][15:4] | ((g < 2) ? 12'h00F : 12'h000);
      sh = ((a[23:12] ^ sm[i][31:20]) & ~dc) == 12'h0;
      if (gh && sh && !found) begin found = 1; w = i; end
    end
    if (!found) return {16'h0, 1'b1, 1'b0, 3'b0, 1'b0};
    else begin
      logic err;
      err = sm[w][3] && wr;
      return {err ? 16'h0 : (16'h1 << w), 1'b0, sm[w][16], sm[w][2:0], err};
    end
  endfunction

  function automatic logic [21:0] outs();
    return {cs, no_sel, wide, wait_cnt, bus_err};
  endfunction

  task automatic access(input logic [23:0] a, input logic wr, input string tag);
    @(negedge clk);
    bus_addr = a; bus_write = wr; bus_strobe = 1'b1;
    @(negedge clk);
    check(tag, {10'h0, outs()}, {10'h0, model(a, wr)});
    bus_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [21:0] held;
    rst = 1'b1; bus_addr = '0; bus_write = 1'b0; bus_strobe = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 16; i++) sm[i] = 32'h00010006;
    for (int g = 0; g < 4; g++)  gm[g] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset outputs", {10'h0, outs()}, 32'h0);

    // R4 R5 reset values and unmapped indices
    for (int i = 0; i < 20; i++) reg_chk(i, (i < 16) ? "R4 reset readback" : "R5 reset readback");
    reg_wr(25, 32'hDEADBEEF);
    reg_chk(25, "R4 unmapped index");

    // R8 reset configuration: select 0 covers 0x00xxxx, 16-bit, 6 waits
    access(24'h005ABC, 1'b0, "R8 reset cfg read");
    access(24'h00F123, 1'b1, "R8 reset cfg write");
    access(24'h015000, 1'b0, "R7 reset cfg miss");

    // configuration
    for (int g = 0; g < 4; g++) begin
      logic [15:0] gv [4] = '{16'h100F, 16'h2000, 16'h4003, 16'h807F};
      reg_wr(16 + g, 32'hABCD0000 | 32'(gv[g]));
    end
    reg_wr(0,  mk(12'h12A, 12'h005, 0, 0, 1));
    reg_wr(1,  mk(12'h100, 12'h0F0, 1, 1, 2));
    reg_wr(2,  mk(12'h1F0, 12'h000, 1, 0, 3));
    reg_wr(3,  mk(12'h000, 12'hFF0, 0, 0, 4));
    reg_wr(4,  mk(12'h210, 12'h000, 1, 0, 5));
    reg_wr(5,  mk(12'h200, 12'h000, 0, 1, 7));
    reg_wr(6,  mk(12'h200, 12'h000, 1, 0, 0));
    reg_wr(8,  mk(12'h401, 12'h000, 0, 0, 1));
    reg_wr(9,  mk(12'h410, 12'h00F, 0, 1, 2));
    reg_wr(10, mk(12'h420, 12'h1FF, 1, 0, 3));
    reg_wr(12, mk(12'h800, 12'h3FF, 1, 0, 4));
    reg_wr(13, mk(12'hF00, 12'h0FF, 0, 1, 5));
    reg_wr(14, mk(12'hC00, 12'h000, 1, 1, 6));
    reg_wr(15, mk(12'h000, 12'hFFF, 0, 0, 7));
    for (int i = 0; i < 20; i++) reg_chk(i, (i < 16) ? "R4 cfg readback" : "R5 cfg readback");

    // full sweep of address bits 23..12, reads and writes
    for (int k = 0; k < 4096; k++) begin
      logic [23:0] a;
      a = {12'(k), 12'((k * 37) & 12'hFFF)};
      access(a, 1'b0, "R1 R2 R3 R6 R7 R8 sweep read");
      access(a, 1'b1, "R1 R2 R3 R6 R7 R8 R9 sweep write");
    end

    // R10 hold while strobe stays high, then clear
    @(negedge clk);
    bus_addr = 24'h122000; bus_write = 1'b0; bus_strobe = 1'b1;
    @(negedge clk);
    held = model(24'h122000, 1'b0);
    check("R10 capture", {10'h0, outs()}, {10'h0, held});
    bus_addr = 24'h410000; bus_write = 1'b1;
    @(negedge clk);
    check("R10 hold addr change", {10'h0, outs()}, {10'h0, held});
    @(negedge clk);
    check("R10 hold second cycle", {10'h0, outs()}, {10'h0, held});
    bus_strobe = 1'b0;
    @(negedge clk);
    check("R10 clear after strobe", {10'h0, outs()}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule